// File: doc/BRIEF.md
# Trace Filter and PMI Freeze Controller

This block sits next to a branch-trace unit and a bank of performance counters. It holds a debug control register and a global counter-enable register. It gates each branch-message strobe by the current privilege level. It also merges counter overflows and trace-buffer threshold flags into a single performance-monitoring interrupt (PMI).

When a PMI fires, software may have asked the block to freeze branch recording, the counters, or both. The block freezes by clearing the relevant enable bits on the same clock edge that raises the interrupt. Those bits stay clear until software writes them back. The counters, the trace memories and the delivery of the interrupt are outside the block.

Top module: `trace_pmi_ctl`

## Requirements
- R1: While `rst` is high, and on the cycle after it is released, `dbg_ctl`, `gp_en`, `fx_en` and `pmi` are all zero.
- R2: A write with `wr_sel`=0 loads the debug register from `wr_data`. Only bits 0, 9, 10, 11 and 12 are kept, and every other bit reads as zero. A write with `wr_sel`=1 loads `gp_en` from `wr_data[NUM_GP-1:0]` and `fx_en` from `wr_data[16+NUM_FX-1:16]`. The new value shows on the outputs after the next rising edge.
- R3: `store_stb` is combinational and is high only when `br_valid` is high and `dbg_ctl[0]` (the recording enable) is set.
- R4: When `dbg_ctl[9]` is set, a message at privilege level 0 (OS) gives no `store_stb`.
- R5: When `dbg_ctl[10]` is set, a message at any privilege level other than 0 (user) gives no `store_stb`.
- R6: A pulse on `gp_ovf[i]` counts as a PMI source only when `gp_pmi_en[i]` is high in the same cycle.
- R7: A pulse on `fx_ovf[j]` counts as a PMI source only when bit 3 of the 4-bit field `fx_ctrl[4j+3:4j]` is set.
- R8: Each trace-buffer threshold flag (`prec_buf_thr`, `br_buf_thr`) counts as a PMI source only in the cycle it rises. A flag held high yields one PMI.
- R9: `pmi` is registered. It is high in exactly the cycle after each cycle in which at least one qualified source is present.
- R10: When `dbg_ctl[11]` is set and a PMI fires, `dbg_ctl[0]` clears on the same edge that raises `pmi`. It stays clear until software writes it to 1.
- R11: When `dbg_ctl[12]` is set and a PMI fires, all bits of `gp_en` and `fx_en` clear on the same edge that raises `pmi`.
- R12: If a software write lands in the same cycle as a freeze, the freeze wins for the enable bits it clears. Every other written bit takes the written value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Register write strobe |
| wr_sel | input | 1 | 0 selects the debug register, 1 selects the counter-enable register |
| wr_data | input | 32 | Write data |
| cpl | input | 2 | Current privilege level; 0 is OS, other values are user |
| br_valid | input | 1 | Branch message valid |
| gp_ovf | input | NUM_GP | General counter overflow pulses |
| gp_pmi_en | input | NUM_GP | Per general counter interrupt enables |
| fx_ovf | input | NUM_FX | Fixed counter overflow pulses |
| fx_ctrl | input | 4*NUM_FX | Fixed counter control fields, 4 bits each |
| prec_buf_thr | input | 1 | Precise-event buffer threshold flag |
| br_buf_thr | input | 1 | Branch-trace buffer threshold flag |
| store_stb | output | 1 | Filtered message store/send strobe |
| pmi | output | 1 | Performance-monitoring interrupt pulse |
| dbg_ctl | output | 13 | Live debug control register |
| gp_en | output | NUM_GP | Live general counter enables |
| fx_en | output | NUM_FX | Live fixed counter enables |

## Verification
`store_stb` is combinational, so the bench compares it in the same cycle that its inputs are driven. The bench samples it partway through the low phase, after the inputs have settled. Register writes, `pmi` and freeze clearing all appear one rising edge after the cycle that causes them. The reference model therefore updates its state at each rising edge from the inputs held over the previous low phase. Every output is compared against the model once per cycle, just before the next edge, so a result that arrives a cycle early or late is reported in that cycle.

// File: rtl/trace_pmi_pkg.sv
`timescale 1ns/1ps
package trace_pmi_pkg;

    localparam int DBG_W        = 13;
    localparam int LBR_BIT      = 0;
    localparam int SUP_OS_BIT   = 9;
    localparam int SUP_USR_BIT  = 10;
    localparam int FRZ_LBR_BIT  = 11;
    localparam int FRZ_CNT_BIT  = 12;
    localparam logic [DBG_W-1:0] DBG_MASK = 13'h1E01;

    localparam int FX_FIELD_W   = 4;
    localparam int FX_IE_POS    = 3;
    localparam int FX_EN_BASE   = 16;
    localparam int WDATA_W      = 32;

    typedef enum logic {
        SEL_DBG  = 1'b0,
        SEL_GCTL = 1'b1
    } reg_sel_e;

    typedef struct packed {
        logic frz_cnt;
        logic frz_lbr;
        logic sup_usr;
        logic sup_os;
        logic rec_en;
    } dbg_fields_t;

    function automatic dbg_fields_t unpack_dbg(input logic [DBG_W-1:0] r);
        dbg_fields_t f;
        f.frz_cnt = r[FRZ_CNT_BIT];
        f.frz_lbr = r[FRZ_LBR_BIT];
        f.sup_usr = r[SUP_USR_BIT];
        f.sup_os  = r[SUP_OS_BIT];
        f.rec_en  = r[LBR_BIT];
        return f;
    endfunction

    function automatic logic is_os_level(input logic [1:0] lvl);
        return (lvl == 2'd0);
    endfunction

endpackage

// File: rtl/tpf_filter.sv
`timescale 1ns/1ps
module tpf_filter
    import trace_pmi_pkg::*;
(
    input  logic        br_valid,
    input  logic [1:0]  cpl,
    input  dbg_fields_t fields,
    output logic        store_stb
);
    logic suppress;

    always_comb begin
        if (is_os_level(cpl)) suppress = fields.sup_os;
        else                  suppress = fields.sup_usr;
        store_stb = br_valid & fields.rec_en & ~suppress;
    end
endmodule

// File: rtl/tpf_pmi_merge.sv
`timescale 1ns/1ps
module tpf_pmi_merge
    import trace_pmi_pkg::*;
#(
    parameter int NUM_GP = 4,
    parameter int NUM_FX = 3
) (
    input  logic                       clk,
    input  logic                       rst,
    input  logic [NUM_GP-1:0]          gp_ovf,
    input  logic [NUM_GP-1:0]          gp_pmi_en,
    input  logic [NUM_FX-1:0]          fx_ovf,
    input  logic [FX_FIELD_W*NUM_FX-1:0] fx_ctrl,
    input  logic                       prec_buf_thr,
    input  logic                       br_buf_thr,
    output logic                       any_src,
    output logic                       pmi
);
    logic [NUM_FX-1:0] fx_ie;
    logic              prec_d, br_d;
    logic              unused_fx_bits;

    for (genvar j = 0; j < NUM_FX; j++) begin : g_fx_ie
        assign fx_ie[j] = fx_ctrl[j*FX_FIELD_W + FX_IE_POS];
    end
    assign unused_fx_bits = ^fx_ctrl;

    always_comb begin
        any_src = (|(gp_ovf & gp_pmi_en))
                | (|(fx_ovf & fx_ie))
                | (prec_buf_thr & ~prec_d)
                | (br_buf_thr   & ~br_d);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            pmi    <= 1'b0;
            prec_d <= 1'b0;
            br_d   <= 1'b0;
        end else begin
            pmi    <= any_src;
            prec_d <= prec_buf_thr;
            br_d   <= br_buf_thr;
        end
    end
endmodule

// File: rtl/tpf_ctl_regs.sv
`timescale 1ns/1ps
module tpf_ctl_regs
    import trace_pmi_pkg::*;
#(
    parameter int NUM_GP = 4,
    parameter int NUM_FX = 3
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               wr_en,
    input  logic               wr_sel,
    input  logic [WDATA_W-1:0] wr_data,
    input  logic               any_src,
    output logic [DBG_W-1:0]   dbg_q,
    output logic [NUM_GP-1:0]  gp_q,
    output logic [NUM_FX-1:0]  fx_q
);
    reg_sel_e          sel;
    dbg_fields_t       cur;
    logic [DBG_W-1:0]  dbg_nx;
    logic [NUM_GP-1:0] gp_nx;
    logic [NUM_FX-1:0] fx_nx;
    logic              frz_lbr_now, frz_cnt_now;
    logic              unused_wdata;

    assign sel          = reg_sel_e'(wr_sel);
    assign cur          = unpack_dbg(dbg_q);
    assign frz_lbr_now  = any_src & cur.frz_lbr;
    assign frz_cnt_now  = any_src & cur.frz_cnt;
    assign unused_wdata = ^wr_data;

    always_comb begin
        dbg_nx = dbg_q;
        gp_nx  = gp_q;
        fx_nx  = fx_q;
        if (wr_en && sel == SEL_DBG) begin
            dbg_nx = wr_data[DBG_W-1:0] & DBG_MASK;
        end
        if (wr_en && sel == SEL_GCTL) begin
            gp_nx = wr_data[NUM_GP-1:0];
            fx_nx = wr_data[FX_EN_BASE +: NUM_FX];
        end
        if (frz_lbr_now) dbg_nx[LBR_BIT] = 1'b0;
        if (frz_cnt_now) begin
            gp_nx = '0;
            fx_nx = '0;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            dbg_q <= '0;
            gp_q  <= '0;
            fx_q  <= '0;
        end else begin
            dbg_q <= dbg_nx;
            gp_q  <= gp_nx;
            fx_q  <= fx_nx;
        end
    end
endmodule

// File: rtl/trace_pmi_ctl.sv
`timescale 1ns/1ps
module trace_pmi_ctl
    import trace_pmi_pkg::*;
#(
    parameter int NUM_GP = 4,
    parameter int NUM_FX = 3
) (
    input  logic                         clk,
    input  logic                         rst,
    input  logic                         wr_en,
    input  logic                         wr_sel,
    input  logic [31:0]                  wr_data,
    input  logic [1:0]                   cpl,
    input  logic                         br_valid,
    input  logic [NUM_GP-1:0]            gp_ovf,
    input  logic [NUM_GP-1:0]            gp_pmi_en,
    input  logic [NUM_FX-1:0]            fx_ovf,
    input  logic [4*NUM_FX-1:0]          fx_ctrl,
    input  logic                         prec_buf_thr,
    input  logic                         br_buf_thr,
    output logic                         store_stb,
    output logic                         pmi,
    output logic [12:0]                  dbg_ctl,
    output logic [NUM_GP-1:0]            gp_en,
    output logic [NUM_FX-1:0]            fx_en
);
    logic        any_src;
    dbg_fields_t fields;

    assign fields = unpack_dbg(dbg_ctl);

    tpf_filter u_filter (
        .br_valid  (br_valid),
        .cpl       (cpl),
        .fields    (fields),
        .store_stb (store_stb)
    );

    tpf_pmi_merge #(.NUM_GP(NUM_GP), .NUM_FX(NUM_FX)) u_merge (
        .clk          (clk),
        .rst          (rst),
        .gp_ovf       (gp_ovf),
        .gp_pmi_en    (gp_pmi_en),
        .fx_ovf       (fx_ovf),
        .fx_ctrl      (fx_ctrl),
        .prec_buf_thr (prec_buf_thr),
        .br_buf_thr   (br_buf_thr),
        .any_src      (any_src),
        .pmi          (pmi)
    );

    tpf_ctl_regs #(.NUM_GP(NUM_GP), .NUM_FX(NUM_FX)) u_regs (
        .clk     (clk),
        .rst     (rst),
        .wr_en   (wr_en),
        .wr_sel  (wr_sel),
        .wr_data (wr_data),
        .any_src (any_src),
        .dbg_q   (dbg_ctl),
        .gp_q    (gp_en),
        .fx_q    (fx_en)
    );
endmodule

// File: rtl/trace_pmi_ctl_chk.sv
`timescale 1ns/1ps
module trace_pmi_ctl_chk #(
    parameter int NUM_GP = 4,
    parameter int NUM_FX = 3
) (
    input logic                clk,
    input logic                rst,
    input logic [1:0]          cpl,
    input logic                br_valid,
    input logic [NUM_GP-1:0]   gp_ovf,
    input logic [NUM_GP-1:0]   gp_pmi_en,
    input logic [NUM_FX-1:0]   fx_ovf,
    input logic [4*NUM_FX-1:0] fx_ctrl,
    input logic                prec_buf_thr,
    input logic                br_buf_thr,
    input logic                store_stb,
    input logic                pmi,
    input logic [12:0]         dbg_ctl,
    input logic [NUM_GP-1:0]   gp_en,
    input logic [NUM_FX-1:0]   fx_en
);
    logic [NUM_FX-1:0] ie;
    logic              some_src;
    logic              unused_ctrl;

    always_comb begin
        for (int j = 0; j < NUM_FX; j++) ie[j] = fx_ctrl[4*j+3];
        some_src = (|(gp_ovf & gp_pmi_en)) | (|(fx_ovf & ie)) | prec_buf_thr | br_buf_thr;
    end
    assign unused_ctrl = ^fx_ctrl;

    AST_RESET_CLEAR: assert property (@(posedge clk)
        rst |=> (dbg_ctl == 13'd0 && gp_en == '0 && fx_en == '0 && !pmi)); // R1

    AST_STORE_NEEDS_EN: assert property (@(posedge clk) disable iff (rst)
        store_stb |-> (br_valid && dbg_ctl[0])); // R3

    AST_OS_SUPPRESS: assert property (@(posedge clk) disable iff (rst)
        (cpl == 2'd0 && dbg_ctl[9]) |-> !store_stb); // R4

    AST_USR_SUPPRESS: assert property (@(posedge clk) disable iff (rst)
        (cpl != 2'd0 && dbg_ctl[10]) |-> !store_stb); // R5

    AST_PMI_HAS_SOURCE: assert property (@(posedge clk) disable iff (rst)
        pmi |-> $past(some_src)); // R9

    AST_FREEZE_LBR: assert property (@(posedge clk) disable iff (rst)
        (pmi && $past(dbg_ctl[11])) |-> !dbg_ctl[0]); // R10

    AST_FREEZE_CNT: assert property (@(posedge clk) disable iff (rst)
        (pmi && $past(dbg_ctl[12])) |-> (gp_en == '0 && fx_en == '0)); // R11
endmodule

bind trace_pmi_ctl trace_pmi_ctl_chk #(.NUM_GP(NUM_GP), .NUM_FX(NUM_FX)) u_chk (.*);

// File: tb/tb_trace_pmi_ctl.sv
`timescale 1ns/1ps
module tb_trace_pmi_ctl;
    localparam int NG = 4;
    localparam int NF = 3;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          wr_en = 1'b0;
    logic          wr_sel = 1'b0;
    logic [31:0]   wr_data = '0;
    logic [1:0]    cpl = '0;
    logic          br_valid = 1'b0;
    logic [NG-1:0] gp_ovf = '0;
    logic [NG-1:0] gp_pmi_en = '0;
    logic [NF-1:0] fx_ovf = '0;
    logic [4*NF-1:0] fx_ctrl = '0;
    logic          prec_buf_thr = 1'b0;
    logic          br_buf_thr = 1'b0;
    logic          store_stb, pmi;
    logic [12:0]   dbg_ctl;
    logic [NG-1:0] gp_en;
    logic [NF-1:0] fx_en;

    always #5 clk = ~clk;

    trace_pmi_ctl #(.NUM_GP(NG), .NUM_FX(NF)) dut (.*);

    int    checks = 0;
    int    errors = 0;
    string cur_req = "R1";
    bit    done = 0;

    // behavioural reference state
    logic [12:0]   m_dbg = '0;
    logic [NG-1:0] m_gp = '0;
    logic [NF-1:0] m_fx = '0;
    logic          m_pmi = 1'b0;
    logic          m_pb = 1'b0, m_bb = 1'b0;

    always @(posedge clk) begin
        if (rst) begin
            m_dbg = '0; m_gp = '0; m_fx = '0; m_pmi = 1'b0; m_pb = 1'b0; m_bb = 1'b0;
        end else begin
            bit fire;
            fire = 0;
            for (int i = 0; i < NG; i++) if (gp_ovf[i] && gp_pmi_en[i]) fire = 1;
            for (int j = 0; j < NF; j++) if (fx_ovf[j] && fx_ctrl[4*j+3]) fire = 1;
            if (prec_buf_thr && !m_pb) fire = 1;
            if (br_buf_thr && !m_bb) fire = 1;
            if (wr_en && !wr_sel) begin
                m_dbg = '0;
                m_dbg[0] = wr_data[0];  m_dbg[9] = wr_data[9];  m_dbg[10] = wr_data[10];
                m_dbg[11] = wr_data[11]; m_dbg[12] = wr_data[12];
                if (fire && $past(dbg_ctl[11])) m_dbg[0] = 1'b0;
            end else if (fire && m_dbg[11]) begin
                m_dbg[0] = 1'b0;
            end
            if (wr_en && wr_sel) begin
                m_gp = wr_data[NG-1:0];
                m_fx = wr_data[16 +: NF];
            end
            if (fire && ((wr_en && !wr_sel) ? $past(dbg_ctl[12]) : m_dbg[12])) begin
                m_gp = '0; m_fx = '0;
            end
            m_pmi = fire;
            m_pb = prec_buf_thr; m_bb = br_buf_thr;
        end
    end

    task automatic chk(input logic [31:0] act, input logic [31:0] exp, input string what);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s actual=%0h expected=%0h", cur_req, what, act, exp);
        end
    endtask

    task automatic check_all();
        logic exp_stb, sup;
        sup = (cpl == 2'd0) ? m_dbg[9] : m_dbg[10];
        exp_stb = br_valid & m_dbg[0] & ~sup;
        chk({31'd0, store_stb}, {31'd0, exp_stb}, "store_stb");
        chk({31'd0, pmi}, {31'd0, m_pmi}, "pmi");
        chk({19'd0, dbg_ctl}, {19'd0, m_dbg}, "dbg_ctl");
        chk({{(32-NG){1'b0}}, gp_en}, {{(32-NG){1'b0}}, m_gp}, "gp_en");
        chk({{(32-NF){1'b0}}, fx_en}, {{(32-NF){1'b0}}, m_fx}, "fx_en");
    endtask

    // inputs are set just after a falling edge; outputs compared 3 ns later
    task automatic cyc();
        #3;
        check_all();
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic wr(input logic sel, input logic [31:0] d);
        wr_en = 1'b1; wr_sel = sel; wr_data = d;
        cyc();
        wr_en = 1'b0; wr_data = '0;
    endtask

    task automatic idle(input int n);
        for (int k = 0; k < n; k++) cyc();
    endtask

    initial begin
        #1_000_000;
        if (!done) begin
            errors++;
            $display("FAIL watchdog expired actual=0 expected=1");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        @(negedge clk);
        cur_req = "R1";
        idle(3);
        rst = 1'b0;
        idle(2);

        cur_req = "R2";
        wr(1'b0, 32'hFFFF_E7FF);   // bits 11/12 clear so no freeze yet
        idle(1);
        wr(1'b0, 32'h0000_1E01);
        wr(1'b0, 32'h0000_0001);
        wr(1'b1, 32'hFFFF_FFFF);
        idle(1);

        cur_req = "R3";
        br_valid = 1'b1;
        for (int l = 0; l < 4; l++) begin cpl = l[1:0]; cyc(); end
        wr(1'b0, 32'h0);
        cpl = 2'd0; cyc();
        cpl = 2'd2; cyc();

        cur_req = "R4";
        wr(1'b0, 32'h0000_0201);
        for (int l = 0; l < 4; l++) begin cpl = l[1:0]; cyc(); end

        cur_req = "R5";
        wr(1'b0, 32'h0000_0401);
        for (int l = 0; l < 4; l++) begin cpl = l[1:0]; cyc(); end
        br_valid = 1'b0;

        cur_req = "R6";
        gp_pmi_en = 4'b0101;
        for (int i = 0; i < NG; i++) begin
            gp_ovf = '0; gp_ovf[i] = 1'b1; cyc();
            gp_ovf = '0; cyc();
        end

        cur_req = "R7";
        fx_ctrl = 12'h807;          // field 2 interrupt bit set, field 0 only low bits
        for (int j = 0; j < NF; j++) begin
            fx_ovf = '0; fx_ovf[j] = 1'b1; cyc();
            fx_ovf = '0; cyc();
        end

        cur_req = "R8";
        prec_buf_thr = 1'b1; idle(4);
        prec_buf_thr = 1'b0; idle(1);
        br_buf_thr = 1'b1; idle(3);
        br_buf_thr = 1'b0; idle(1);

        cur_req = "R9";
        gp_ovf = 4'b0001; idle(3);
        gp_ovf = '0; idle(1);
        gp_ovf = 4'b0001; fx_ovf = 3'b100; cyc();
        gp_ovf = '0; fx_ovf = '0; idle(2);

        cur_req = "R10";
        wr(1'b0, 32'h0000_0801);
        wr(1'b1, 32'hFFFF_FFFF);
        br_valid = 1'b1;
        gp_ovf = 4'b0100; cyc();
        gp_ovf = '0; idle(4);
        wr(1'b0, 32'h0000_0801);
        idle(2);
        wr(1'b0, 32'h0000_0001);    // freeze off: PMI leaves recording on
        gp_ovf = 4'b0001; cyc();
        gp_ovf = '0; idle(2);

        cur_req = "R11";
        wr(1'b0, 32'h0000_1001);
        wr(1'b1, 32'h0007_000F);
        fx_ovf = 3'b100; cyc();
        fx_ovf = '0; idle(3);

        cur_req = "R12";
        wr(1'b0, 32'h0000_1801);
        wr(1'b1, 32'hFFFF_FFFF);
        wr_en = 1'b1; wr_sel = 1'b0; wr_data = 32'h0000_1A01; gp_ovf = 4'b0001;
        cyc();
        wr_en = 1'b0; gp_ovf = '0; idle(2);
        wr_en = 1'b1; wr_sel = 1'b1; wr_data = 32'hFFFF_FFFF; prec_buf_thr = 1'b1;
        cyc();
        wr_en = 1'b0; prec_buf_thr = 1'b0; idle(2);
        br_valid = 1'b0;

        done = 1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule